// File: doc/BRIEF.md
# Interlocked Handshake Word Read Link

This block moves one data word from a small memory to a requesting agent over a shared set of lines that carry the address first and the returned word afterwards. The two parties run on unrelated clocks. They coordinate through three control wires: a read-request line, a data-ready line, and one acknowledge line that both sides drive (wired-OR). Every control edge is answered by the partner before the next step is taken, so the transfer is correct whatever the ratio of the two clocks.

The requester side presents a local start/address/busy/done/data interface in its own clock domain. The memory side owns a register array that is written through a local load port in the memory clock domain. Each side samples the partner's control wires through a two-flop synchroniser. The shared lines are bundled with the control wires: a side only samples them after the synchronised control edge that announces them.

The transfer runs as a fixed sequence. The requester drives the address and raises the request. The memory captures the address and raises acknowledge. The requester releases the lines and drops the request. The memory drops acknowledge. Once it sees its own acknowledge low again, the memory drives the word and raises data-ready. The requester captures the word and raises acknowledge. The memory drops data-ready and releases the lines. The requester then drops acknowledge. Once acknowledge is seen low, the requester pulses done.

Top module: `hs_read_link`

## Requirements
- R1: While reset is held and just after it is released, ReadReq, DataRdy, Ack, busy and done are all 0 and the shared lines read 0.
- R2: A read started with address A ends with done high and the data output equal to the word stored at array index A.
- R3: A start pulse accepted while idle makes busy 1 on the next requester clock edge. A start while busy is ignored, so the completed read returns the word of the first address.
- R4: From the edge that raises ReadReq until the requester sees Ack, ReadReq stays 1 and the low address bits of the shared lines equal the requested address.
- R5: DataRdy rises only after the memory has seen ReadReq low and Ack low. ReadReq and DataRdy are never 1 together. DataRdy falls only after the memory has seen Ack high.
- R6: At most one side drives the shared lines at a time. Whenever DataRdy is 1, the lines carry exactly the stored word.
- R7: Done is a one-cycle pulse. When done is 1, busy, ReadReq, DataRdy and Ack are all 0.
- R8: A write on the memory load port (mem_we=1 at a memory clock edge) replaces the word at mem_waddr, and later reads of that address return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_req | input | 1 | Requester clock |
| rst_req | input | 1 | Requester synchronous reset, active high |
| clk_mem | input | 1 | Memory clock, unrelated to clk_req |
| rst_mem | input | 1 | Memory synchronous reset, active high |
| rq_start | input | 1 | Start pulse for a read (requester domain) |
| rq_addr | input | ADDR_W | Word address for the read |
| rq_busy | output | 1 | A read is in progress |
| rq_done | output | 1 | One-cycle pulse when the word is available |
| rq_data | output | DATA_W | Word returned by the last read |
| mem_we | input | 1 | Load-port write enable (memory domain) |
| mem_waddr | input | ADDR_W | Load-port write address |
| mem_wdata | input | DATA_W | Load-port write data |
| link_readreq | output | 1 | Read-request control wire |
| link_datardy | output | 1 | Data-ready control wire |
| link_ack | output | 1 | Shared acknowledge wire (OR of both sides) |
| link_bus | output | BUS_W | Shared address/data lines |

## Verification
The two functions that can meet in one cycle are the hand-over of the shared lines between the requester's address phase and the memory's data phase, and a new start arriving while the previous transfer is still closing. Both are provoked by back-to-back reads issued as soon as done appears, together with a second start pulsed in the cycle after acceptance. A monitor on every requester half-cycle judges the hand-over: the lines must hold the exact address while ReadReq is up and the exact stored word while DataRdy is up, and the two control wires must never be up together. The extra start is judged by the returned word, which must belong to the first address.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_ADDR,
    RQ_ALOW,
    RQ_DWAIT,
    RQ_DACK,
    RQ_FIN
  } rq_state_t;

  typedef enum logic [2:0] {
    MS_IDLE,
    MS_ACKHI,
    MS_ECHO,
    MS_DRIVE,
    MS_CLOSE
  } ms_state_t;

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/hs_requester.sv
module hs_requester
  import hs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] data,
  input  logic [BUS_W-1:0]  lines,
  input  logic              ack_async,
  input  logic              drdy_async,
  output logic              rreq_o,
  output logic              ack_o,
  output logic              oe_o,
  output logic [BUS_W-1:0]  drv_o
);

  rq_state_t state;
  logic      ack_s;
  logic      drdy_s;

  hs_sync2 #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ack_async, drdy_async}),
    .q   ({ack_s, drdy_s})
  );

  assign busy = (state != RQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RQ_IDLE;
      rreq_o <= 1'b0;
      ack_o  <= 1'b0;
      oe_o   <= 1'b0;
      drv_o  <= '0;
      done   <= 1'b0;
      data   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        RQ_IDLE: begin
          if (start) begin
            drv_o  <= BUS_W'(addr);
            oe_o   <= 1'b1;
            rreq_o <= 1'b1;
            state  <= RQ_ADDR;
          end
        end
        RQ_ADDR: begin
          if (ack_s) begin
            rreq_o <= 1'b0;
            oe_o   <= 1'b0;
            state  <= RQ_ALOW;
          end
        end
        RQ_ALOW: begin
          if (!ack_s) state <= RQ_DWAIT;
        end
        RQ_DWAIT: begin
          if (drdy_s) begin
            data  <= lines[DATA_W-1:0];
            ack_o <= 1'b1;
            state <= RQ_DACK;
          end
        end
        RQ_DACK: begin
          if (!drdy_s) begin
            ack_o <= 1'b0;
            state <= RQ_FIN;
          end
        end
        RQ_FIN: begin
          if (!ack_s) begin
            done  <= 1'b1;
            state <= RQ_IDLE;
          end
        end
        default: state <= RQ_IDLE;
      endcase
    end
  end

  // R4: request held until acknowledge is seen
  a_r4_hold_request: assert property (@(posedge clk) disable iff (rst)
    (rreq_o && !ack_s) |=> rreq_o);

  // R4: request only drops after acknowledge was seen
  a_r4_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(rreq_o) |-> $past(ack_s));

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: accepted start makes busy
  a_r3_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import hs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BUS_W-1:0]  lines,
  input  logic              rreq_async,
  input  logic              ack_async,
  output logic              ack_o,
  output logic              drdy_o,
  output logic              oe_o,
  output logic [BUS_W-1:0]  drv_o
);

  localparam int DEPTH = 2 ** ADDR_W;

  ms_state_t         state;
  logic              rreq_s;
  logic              ack_s;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] store [DEPTH];

  hs_sync2 #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rreq_async, ack_async}),
    .q   ({rreq_s, ack_s})
  );

  // block-RAM style array: one write port, registered read
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rd_q <= store[addr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= MS_IDLE;
      ack_o  <= 1'b0;
      drdy_o <= 1'b0;
      oe_o   <= 1'b0;
      drv_o  <= '0;
      addr_q <= '0;
    end else begin
      unique case (state)
        MS_IDLE: begin
          if (rreq_s) begin
            addr_q <= lines[ADDR_W-1:0];
            ack_o  <= 1'b1;
            state  <= MS_ACKHI;
          end
        end
        MS_ACKHI: begin
          if (!rreq_s) begin
            ack_o <= 1'b0;
            state <= MS_ECHO;
          end
        end
        MS_ECHO: begin
          if (!ack_s) begin
            drv_o  <= BUS_W'(rd_q);
            oe_o   <= 1'b1;
            drdy_o <= 1'b1;
            state  <= MS_DRIVE;
          end
        end
        MS_DRIVE: begin
          if (ack_s) begin
            drdy_o <= 1'b0;
            oe_o   <= 1'b0;
            state  <= MS_CLOSE;
          end
        end
        MS_CLOSE: begin
          if (!ack_s) state <= MS_IDLE;
        end
        default: state <= MS_IDLE;
      endcase
    end
  end

  // R5: data-ready rises only once request and acknowledge are seen low
  a_r5_ready_after_release: assert property (@(posedge clk) disable iff (rst)
    $rose(drdy_o) |-> ($past(!rreq_s) && $past(!ack_s)));

  // R5: data-ready falls only after acknowledge was seen
  a_r5_ready_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy_o) |-> $past(ack_s));

  // R5: data-ready held while no acknowledge
  a_r5_ready_hold: assert property (@(posedge clk) disable iff (rst)
    (drdy_o && !ack_s) |=> drdy_o);

endmodule

// File: rtl/hs_read_link.sv
module hs_read_link #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_req,
  input  logic              rst_req,
  input  logic              clk_mem,
  input  logic              rst_mem,
  input  logic              rq_start,
  input  logic [ADDR_W-1:0] rq_addr,
  output logic              rq_busy,
  output logic              rq_done,
  output logic [DATA_W-1:0] rq_data,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic              link_readreq,
  output logic              link_datardy,
  output logic              link_ack,
  output logic [((ADDR_W > DATA_W) ? ADDR_W : DATA_W)-1:0] link_bus
);

  localparam int BUS_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

  logic             req_ack;
  logic             mem_ack;
  logic             req_oe;
  logic             mem_oe;
  logic [BUS_W-1:0] req_drv;
  logic [BUS_W-1:0] mem_drv;

  assign link_ack = req_ack | mem_ack;
  assign link_bus = req_oe ? req_drv : (mem_oe ? mem_drv : '0);

  hs_requester #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BUS_W  (BUS_W)
  ) u_req (
    .clk        (clk_req),
    .rst        (rst_req),
    .start      (rq_start),
    .addr       (rq_addr),
    .busy       (rq_busy),
    .done       (rq_done),
    .data       (rq_data),
    .lines      (link_bus),
    .ack_async  (link_ack),
    .drdy_async (link_datardy),
    .rreq_o     (link_readreq),
    .ack_o      (req_ack),
    .oe_o       (req_oe),
    .drv_o      (req_drv)
  );

  hs_responder #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BUS_W  (BUS_W)
  ) u_mem (
    .clk        (clk_mem),
    .rst        (rst_mem),
    .we         (mem_we),
    .waddr      (mem_waddr),
    .wdata      (mem_wdata),
    .lines      (link_bus),
    .rreq_async (link_readreq),
    .ack_async  (link_ack),
    .ack_o      (mem_ack),
    .drdy_o     (link_datardy),
    .oe_o       (mem_oe),
    .drv_o      (mem_drv)
  );

  // R6: never two drivers on the shared lines (seen from both clocks)
  a_r6_single_driver_req: assert property (@(posedge clk_req)
    disable iff (rst_req || rst_mem) !(req_oe && mem_oe));

  a_r6_single_driver_mem: assert property (@(posedge clk_mem)
    disable iff (rst_req || rst_mem) !(req_oe && mem_oe));

endmodule

// File: tb/hs_read_link_bench.sv
module hs_read_link_bench;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NW = 2 ** AW;

  logic          clk_req = 1'b0;
  logic          clk_mem = 1'b0;
  logic          rst_req = 1'b1;
  logic          rst_mem = 1'b1;
  logic          rq_start = 1'b0;
  logic [AW-1:0] rq_addr = '0;
  logic          rq_busy;
  logic          rq_done;
  logic [DW-1:0] rq_data;
  logic          mem_we = 1'b0;
  logic [AW-1:0] mem_waddr = '0;
  logic [DW-1:0] mem_wdata = '0;
  logic          link_readreq;
  logic          link_datardy;
  logic          link_ack;
  logic [DW-1:0] link_bus;

  int            n_tests = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;
  bit            active = 1'b0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] shadow [NW];

  always #10 clk_req = ~clk_req;   // 50 MHz
  always #17 clk_mem = ~clk_mem;   // unrelated memory clock

  hs_read_link #(.ADDR_W(AW), .DATA_W(DW)) u_hs_read_link (
    .clk_req      (clk_req),
    .rst_req      (rst_req),
    .clk_mem      (clk_mem),
    .rst_mem      (rst_mem),
    .rq_start     (rq_start),
    .rq_addr      (rq_addr),
    .rq_busy      (rq_busy),
    .rq_done      (rq_done),
    .rq_data      (rq_data),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr),
    .mem_wdata    (mem_wdata),
    .link_readreq (link_readreq),
    .link_datardy (link_datardy),
    .link_ack     (link_ack),
    .link_bus     (link_bus)
  );

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 16'h1357) ^ 16'hA5C3;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [AW-1:0] a, input logic [DW-1:0] w);
    @(negedge clk_mem);
    mem_we    = 1'b1;
    mem_waddr = a;
    mem_wdata = w;
    @(negedge clk_mem);
    mem_we    = 1'b0;
    shadow[a] = w;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_req);
      if (rq_done) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  // read with optional extra start one cycle after acceptance (R3)
  task automatic do_read(input logic [AW-1:0] a, input bit poke,
                         input logic [AW-1:0] other);
    bit ok;
    @(negedge clk_req);
    cur_addr = a;
    active   = 1'b1;
    rq_addr  = a;
    rq_start = 1'b1;
    @(negedge clk_req);
    rq_start = 1'b0;
    check("R3 busy after start", DW'(rq_busy), DW'(1));
    if (poke) begin
      rq_addr  = other;
      rq_start = 1'b1;
      @(negedge clk_req);
      rq_start = 1'b0;
    end
    wait_done(ok);
    check("R2 done seen", DW'(ok), DW'(1));
    if (ok) begin
      check(poke ? "R3 extra start ignored" : "R2 read data", rq_data, shadow[a]);
      check("R7 busy low at done", DW'(rq_busy), DW'(0));
      check("R7 lines idle at done",
            DW'({link_readreq, link_datardy, link_ack}), DW'(0));
      @(negedge clk_req);
      check("R7 done one cycle", DW'(rq_done), DW'(0));
    end
    active = 1'b0;
  endtask

  // protocol monitor on requester half-cycles
  always @(negedge clk_req) begin
    if (active && !finished) begin
      if (link_readreq && link_datardy) begin
        n_tests++;
        n_fail++;
        $display("FAIL R5 overlap actual=%b%b expected=0", link_readreq, link_datardy);
      end
      if (link_readreq)
        check("R4 address on lines", DW'(link_bus[AW-1:0]), DW'(cur_addr));
      if (link_datardy)
        check("R6 word on lines", link_bus, shadow[cur_addr]);
    end
  end

  initial begin
    repeat (150000) @(posedge clk_req);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (6) @(negedge clk_req);
    check("R1 reset controls",
          DW'({link_readreq, link_datardy, link_ack, rq_busy, rq_done}), DW'(0));
    @(negedge clk_req);
    rst_req = 1'b0;
    @(negedge clk_mem);
    rst_mem = 1'b0;
    repeat (3) @(negedge clk_req);
    check("R1 after reset controls",
          DW'({link_readreq, link_datardy, link_ack, rq_busy, rq_done}), DW'(0));
    check("R1 lines idle", link_bus, '0);

    for (int a = 0; a < NW; a++) load_word(AW'(a), init_word(a));

    // directed corners
    do_read(AW'(0), 1'b0, '0);
    do_read(AW'(NW - 1), 1'b0, '0);
    do_read(AW'(5), 1'b1, AW'(9));

    // R8: overwrite through load port then read back
    load_word(AW'(3), 16'hBEEF);
    do_read(AW'(3), 1'b0, '0);
    load_word(AW'(NW - 1), 16'h0000);
    do_read(AW'(NW - 1), 1'b0, '0);   // R8 all-zero word

    // random back-to-back reads
    for (int k = 0; k < 24; k++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom);
      if (k % 6 == 5) load_word(ra, DW'($urandom));
      do_read(ra, (k % 4 == 1), AW'($urandom));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule